// File: doc/BRIEF.md
# Wear-Levelling Block Allocator

This block tracks a small table of flash erase blocks. For each block it keeps a saturating erase counter and a state: free, holding data, or retired as bad. When the write path needs a fresh block, it raises an allocation request. The block walks the table, one entry per clock, and hands back the free block that has been erased the fewest times. The chosen block then counts as holding data.

The same walk also reads how worn the two pools are. Between allocations, any change to the table (an erase completion, a release, a retirement, a grant or a finished swap) starts a background walk. That walk compares the most-worn free block with the least-worn data block. When the first exceeds the second by more than a programmable threshold, the block posts a swap request. The request names the cold data block, whose contents should move, and the worn free block, which should receive them. The relocation itself, the flash timing and the logical map are left to the surrounding logic.

Both result paths use valid/ready. A grant, once valid, stays valid with fixed contents until the consumer takes it. The allocator accepts no new request while a grant is pending. A swap request likewise holds its indices until it is taken, and no second swap is posted while one is outstanding. The strobe inputs are single-cycle events and are never back-pressured.

Top module: `wear_level_alloc`

## Requirements
- R1: After reset every block is free with an erase count of zero; alloc_ready is high and grant_valid, swap_valid and busy are low.
- R2: An accepted allocation grants the free block with the smallest erase count, ties going to the lowest index; grant_valid rises on the NUM_BLK+1th rising edge after the accepting edge.
- R3: A granted block holds data from then on and is not granted again until it is released.
- R4: When no block is free, the allocation still completes, with grant_none at 1 and grant_idx at 0.
- R5: alloc_ready is high only while the allocator is idle; a pending grant keeps grant_valid, grant_idx and grant_none unchanged until grant_ready is high on a rising edge.
- R6: Each erase_stb adds one to the named block's count, and a count at 2^CNT_W-1 stays there instead of wrapping.
- R7: bad_stb retires a block permanently; a retired block is never granted, and a release aimed at it leaves it retired.
- R8: rel_stb on a data block returns it to the free pool.
- R9: A background walk posts a swap only when the highest free count exceeds the lowest data count by strictly more than thresh; swap_hot_idx is the highest-count free block and swap_cold_idx the lowest-count data block, ties to the lowest index; when idle, swap_valid rises NUM_BLK+2 edges after the table change.
- R10: A posted swap keeps swap_valid and both indices unchanged until swap_ready is high, no other swap is posted meanwhile, and at the handshake the cold block becomes free and the hot block becomes data.
- R11: busy is high while a walk runs or a grant waits to be taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| thresh | input | CNT_W | Wear gap that must be exceeded before a swap |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | Allocator can accept a request |
| grant_valid | output | 1 | Grant result available |
| grant_ready | input | 1 | Consumer takes the grant |
| grant_idx | output | $clog2(NUM_BLK) | Granted block index |
| grant_none | output | 1 | No free block existed |
| erase_stb | input | 1 | One erase of erase_idx finished |
| erase_idx | input | $clog2(NUM_BLK) | Block that was erased |
| bad_stb | input | 1 | Retire bad_idx |
| bad_idx | input | $clog2(NUM_BLK) | Block to retire |
| rel_stb | input | 1 | Return rel_idx to the free pool |
| rel_idx | input | $clog2(NUM_BLK) | Block to release |
| swap_valid | output | 1 | Static swap requested |
| swap_ready | input | 1 | Swap request taken |
| swap_cold_idx | output | $clog2(NUM_BLK) | Rarely rewritten data block to move |
| swap_hot_idx | output | $clog2(NUM_BLK) | Worn free block to receive the data |
| busy | output | 1 | Walk running or grant pending |

## Verification
A grant is due on the NUM_BLK+1th rising edge after the edge that accepts the request. The bench counts edges from acceptance and compares the count with that figure, then checks the grant contents at the falling edge of the handshake cycle. A swap from an idle allocator is due NUM_BLK+2 edges after the edge that captures the triggering strobe, and the bench measures that interval the same way. Every other observation is taken at a falling edge after the allocator has stayed idle for three cycles, so that all walks caused by earlier stimulus have finished.

// File: rtl/wl_pkg.sv
package wl_pkg;
  // Per-block state encoding
  typedef logic [1:0] blk_st_t;
  localparam blk_st_t BS_FREE = 2'd0;
  localparam blk_st_t BS_DATA = 2'd1;
  localparam blk_st_t BS_BAD  = 2'd2;

  typedef enum logic [1:0] {
    CT_IDLE,
    CT_SCAN_ALLOC,
    CT_SCAN_CHECK,
    CT_GRANT
  } ctl_state_e;
endpackage

// File: rtl/wl_entry.sv
module wl_entry
  import wl_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             take,
  input  logic             free_it,
  input  logic             kill,
  output logic [CNT_W-1:0] cnt_o,
  output blk_st_t          st_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
      st_o  <= BS_FREE;
    end else begin
      if (inc && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
      if (kill) begin
        st_o <= BS_BAD;
      end else if (st_o != BS_BAD) begin
        if (take)         st_o <= BS_DATA;
        else if (free_it) st_o <= BS_FREE;
      end
    end
  end

  // R6: a full counter stays full
  a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o == CNT_MAX |=> cnt_o == CNT_MAX);

  // R6: the counter only ever moves up by one
  a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o != $past(cnt_o) |-> cnt_o == $past(cnt_o) + 1'b1);

  // R7: retirement is permanent
  a_r7_bad_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    st_o == BS_BAD |=> st_o == BS_BAD);
endmodule

// File: rtl/wl_scan.sv
module wl_scan
  import wl_pkg::*;
#(
  parameter int NUM_BLK = 32,
  parameter int CNT_W   = 12,
  parameter int IDX_W   = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic [NUM_BLK-1:0][CNT_W-1:0]   cnt_all,
  input  logic [NUM_BLK-1:0][1:0]         st_all,
  output logic                            done,
  output logic                            has_free,
  output logic [IDX_W-1:0]                lo_free_idx,
  output logic [IDX_W-1:0]                hi_free_idx,
  output logic [CNT_W-1:0]                hi_free_cnt,
  output logic                            has_data,
  output logic [IDX_W-1:0]                lo_data_idx,
  output logic [CNT_W-1:0]                lo_data_cnt
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BLK - 1);

  logic             running;
  logic [IDX_W-1:0] ptr;
  logic [CNT_W-1:0] lo_free_cnt;
  logic [CNT_W-1:0] cur_cnt;
  blk_st_t          cur_st;

  assign cur_cnt = cnt_all[ptr];
  assign cur_st  = st_all[ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running     <= 1'b0;
      ptr         <= '0;
      done        <= 1'b0;
      has_free    <= 1'b0;
      has_data    <= 1'b0;
      lo_free_idx <= '0;
      lo_free_cnt <= '0;
      hi_free_idx <= '0;
      hi_free_cnt <= '0;
      lo_data_idx <= '0;
      lo_data_cnt <= '0;
    end else begin
      done <= 1'b0;
      if (start && !running) begin
        running  <= 1'b1;
        ptr      <= '0;
        has_free <= 1'b0;
        has_data <= 1'b0;
      end else if (running) begin
        if (cur_st == BS_FREE) begin
          has_free <= 1'b1;
          if (!has_free || cur_cnt < lo_free_cnt) begin
            lo_free_idx <= ptr;
            lo_free_cnt <= cur_cnt;
          end
          if (!has_free || cur_cnt > hi_free_cnt) begin
            hi_free_idx <= ptr;
            hi_free_cnt <= cur_cnt;
          end
        end
        if (cur_st == BS_DATA) begin
          has_data <= 1'b1;
          if (!has_data || cur_cnt < lo_data_cnt) begin
            lo_data_idx <= ptr;
            lo_data_cnt <= cur_cnt;
          end
        end
        if (ptr == LAST) begin
          running <= 1'b0;
          done    <= 1'b1;
        end else begin
          ptr <= ptr + 1'b1;
        end
      end
    end
  end

  // R2: a result is reported only at the close of a walk
  a_r2_done_ends_walk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !running && $past(running));

  // R11: the controller never restarts a walk in flight
  a_r11_start_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !running);
endmodule

// File: rtl/wear_level_alloc.sv
module wear_level_alloc
  import wl_pkg::*;
#(
  parameter int NUM_BLK = 32,
  parameter int CNT_W   = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [CNT_W-1:0]           thresh,
  input  logic                       alloc_valid,
  output logic                       alloc_ready,
  output logic                       grant_valid,
  input  logic                       grant_ready,
  output logic [$clog2(NUM_BLK)-1:0] grant_idx,
  output logic                       grant_none,
  input  logic                       erase_stb,
  input  logic [$clog2(NUM_BLK)-1:0] erase_idx,
  input  logic                       bad_stb,
  input  logic [$clog2(NUM_BLK)-1:0] bad_idx,
  input  logic                       rel_stb,
  input  logic [$clog2(NUM_BLK)-1:0] rel_idx,
  output logic                       swap_valid,
  input  logic                       swap_ready,
  output logic [$clog2(NUM_BLK)-1:0] swap_cold_idx,
  output logic [$clog2(NUM_BLK)-1:0] swap_hot_idx,
  output logic                       busy
);
  localparam int IDX_W = $clog2(NUM_BLK);

  ctl_state_e                    state;
  logic [NUM_BLK-1:0][CNT_W-1:0] cnt_all;
  logic [NUM_BLK-1:0][1:0]       st_all;

  logic             scan_start, scan_done;
  logic             has_free, has_data;
  logic [IDX_W-1:0] lo_free_idx, hi_free_idx, lo_data_idx;
  logic [CNT_W-1:0] hi_free_cnt, lo_data_cnt;

  logic dirty, dirty_set, check_go;
  logic cand_stale, alloc_take, alloc_retry;
  logic swap_fire, swap_apply, trig;

  // ---------------- table ----------------
  for (genvar gi = 0; gi < NUM_BLK; gi++) begin : g_blk
    localparam logic [IDX_W-1:0] ME = IDX_W'(gi);
    logic hit_take, hit_free;
    assign hit_take = (alloc_take && lo_free_idx == ME) ||
                      (swap_apply && swap_hot_idx == ME);
    assign hit_free = (rel_stb && rel_idx == ME) ||
                      (swap_apply && swap_cold_idx == ME);
    wl_entry #(.CNT_W(CNT_W)) u_ent (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (erase_stb && erase_idx == ME),
      .take    (hit_take),
      .free_it (hit_free),
      .kill    (bad_stb && bad_idx == ME),
      .cnt_o   (cnt_all[gi]),
      .st_o    (st_all[gi])
    );
  end

  // ---------------- walker ----------------
  wl_scan #(.NUM_BLK(NUM_BLK), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_scan (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (scan_start),
    .cnt_all     (cnt_all),
    .st_all      (st_all),
    .done        (scan_done),
    .has_free    (has_free),
    .lo_free_idx (lo_free_idx),
    .hi_free_idx (hi_free_idx),
    .hi_free_cnt (hi_free_cnt),
    .has_data    (has_data),
    .lo_data_idx (lo_data_idx),
    .lo_data_cnt (lo_data_cnt)
  );

  // ---------------- control ----------------
  assign alloc_ready = (state == CT_IDLE);
  assign busy        = (state != CT_IDLE);

  // candidate must still be free and not retired on this very edge
  assign cand_stale  = (st_all[lo_free_idx] != BS_FREE) ||
                       (bad_stb && bad_idx == lo_free_idx);
  assign alloc_retry = (state == CT_SCAN_ALLOC) && scan_done && has_free && cand_stale;
  assign alloc_take  = (state == CT_SCAN_ALLOC) && scan_done && has_free && !cand_stale;
  assign check_go    = (state == CT_IDLE) && !alloc_valid && dirty;
  assign scan_start  = ((state == CT_IDLE) && (alloc_valid || dirty)) || alloc_retry;

  assign swap_fire  = swap_valid && swap_ready;
  assign swap_apply = swap_fire &&
                      st_all[swap_cold_idx] == BS_DATA &&
                      st_all[swap_hot_idx]  == BS_FREE &&
                      !(bad_stb && (bad_idx == swap_cold_idx || bad_idx == swap_hot_idx));

  assign trig = (state == CT_SCAN_CHECK) && scan_done && !swap_valid &&
                has_free && has_data && (hi_free_cnt > lo_data_cnt) &&
                ((hi_free_cnt - lo_data_cnt) > thresh);

  assign dirty_set = erase_stb || bad_stb || rel_stb || alloc_take || swap_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= CT_IDLE;
      dirty         <= 1'b0;
      grant_valid   <= 1'b0;
      grant_idx     <= '0;
      grant_none    <= 1'b0;
      swap_valid    <= 1'b0;
      swap_cold_idx <= '0;
      swap_hot_idx  <= '0;
    end else begin
      if (dirty_set)     dirty <= 1'b1;
      else if (check_go) dirty <= 1'b0;

      case (state)
        CT_IDLE: begin
          if (alloc_valid) state <= CT_SCAN_ALLOC;
          else if (dirty)  state <= CT_SCAN_CHECK;
        end
        CT_SCAN_ALLOC: begin
          if (scan_done && !alloc_retry) begin
            state       <= CT_GRANT;
            grant_valid <= 1'b1;
            grant_none  <= !has_free;
            grant_idx   <= has_free ? lo_free_idx : '0;
          end
        end
        CT_SCAN_CHECK: begin
          if (scan_done) state <= CT_IDLE;
        end
        CT_GRANT: begin
          if (grant_ready) begin
            grant_valid <= 1'b0;
            state       <= CT_IDLE;
          end
        end
        default: state <= CT_IDLE;
      endcase

      if (swap_fire) begin
        swap_valid <= 1'b0;
      end else if (trig) begin
        swap_valid    <= 1'b1;
        swap_cold_idx <= lo_data_idx;
        swap_hot_idx  <= hi_free_idx;
      end
    end
  end

  // R3: a fresh grant names a block that the table now holds as data
  a_r3_grant_taken: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) && !grant_none |-> st_all[grant_idx] == BS_DATA);

  // R5: a pending grant does not change until it is taken
  a_r5_grant_hold: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && !grant_ready |=> grant_valid && $stable(grant_idx) && $stable(grant_none));

  // R5: no request is accepted while a grant waits
  a_r5_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> !alloc_ready);

  // R10: a posted swap does not change until it is taken
  a_r10_swap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    swap_valid && !swap_ready |=> swap_valid && $stable(swap_cold_idx) && $stable(swap_hot_idx));
endmodule

// File: tb/sim_wear_level_alloc.sv
module sim_wear_level_alloc;
  localparam int NB = 8;
  localparam int CW = 12;
  localparam int IW = 3;
  localparam int CMAX = 4095;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] thresh = 12'hFFF;
  logic          alloc_valid = 1'b0;
  logic          alloc_ready;
  logic          grant_valid;
  logic          grant_ready = 1'b1;
  logic [IW-1:0] grant_idx;
  logic          grant_none;
  logic          erase_stb = 1'b0;
  logic [IW-1:0] erase_idx = '0;
  logic          bad_stb = 1'b0;
  logic [IW-1:0] bad_idx = '0;
  logic          rel_stb = 1'b0;
  logic [IW-1:0] rel_idx = '0;
  logic          swap_valid;
  logic          swap_ready = 1'b0;
  logic [IW-1:0] swap_cold_idx;
  logic [IW-1:0] swap_hot_idx;
  logic          busy;

  always #4 clk = ~clk;

  wear_level_alloc #(.NUM_BLK(NB), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .thresh(thresh),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .grant_valid(grant_valid), .grant_ready(grant_ready),
    .grant_idx(grant_idx), .grant_none(grant_none),
    .erase_stb(erase_stb), .erase_idx(erase_idx),
    .bad_stb(bad_stb), .bad_idx(bad_idx),
    .rel_stb(rel_stb), .rel_idx(rel_idx),
    .swap_valid(swap_valid), .swap_ready(swap_ready),
    .swap_cold_idx(swap_cold_idx), .swap_hot_idx(swap_hot_idx),
    .busy(busy)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int mcnt[NB];
  int mst[NB];          // 0 free, 1 data, 2 retired
  int grant_q[$];       // expected grant index, -1 for none
  int swap_q[$];        // expected cold*256+hot

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic int pick_free();
    int best = -1;
    for (int i = 0; i < NB; i++)
      if (mst[i] == 0 && (best < 0 || mcnt[i] < mcnt[best])) best = i;
    return best;
  endfunction

  function automatic int pick_swap();
    int hot = -1;
    int cold = -1;
    for (int i = 0; i < NB; i++) begin
      if (mst[i] == 0 && (hot < 0 || mcnt[i] > mcnt[hot])) hot = i;
      if (mst[i] == 1 && (cold < 0 || mcnt[i] < mcnt[cold])) cold = i;
    end
    if (hot < 0 || cold < 0) return -1;
    if (mcnt[hot] - mcnt[cold] > int'(thresh)) return cold * 256 + hot;
    return -1;
  endfunction

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    if (rst_n) begin
      if (grant_valid && grant_ready) begin
        if (grant_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected grant", int'(grant_idx), -1);
        end else begin
          int e;
          int a;
          e = grant_q.pop_front();
          a = grant_none ? -1 : int'(grant_idx);
          chk(a == e, "R2", "grant index (-1 = none)", a, e);
          if (grant_none) chk(grant_idx == '0, "R4", "grant_idx on no-grant", int'(grant_idx), 0);
        end
      end
      if (swap_valid && swap_ready) begin
        if (swap_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected swap", int'(swap_cold_idx) * 256 + int'(swap_hot_idx), -1);
        end else begin
          int e;
          int a;
          e = swap_q.pop_front();
          a = int'(swap_cold_idx) * 256 + int'(swap_hot_idx);
          chk(a == e, "R9", "swap cold*256+hot", a, e);
        end
      end
    end
  end

  // ---------------- driver tasks ----------------
  task automatic erase(input int idx, input int n);
    @(posedge clk); #1;
    erase_stb = 1'b1; erase_idx = IW'(idx);
    repeat (n) @(posedge clk);
    #1 erase_stb = 1'b0;
    mcnt[idx] = (mcnt[idx] + n > CMAX) ? CMAX : mcnt[idx] + n;
  endtask

  task automatic release_blk(input int idx);
    @(posedge clk); #1;
    rel_stb = 1'b1; rel_idx = IW'(idx);
    @(posedge clk); #1 rel_stb = 1'b0;
    if (mst[idx] == 1) mst[idx] = 0;
  endtask

  task automatic retire(input int idx);
    @(posedge clk); #1;
    bad_stb = 1'b1; bad_idx = IW'(idx);
    @(posedge clk); #1 bad_stb = 1'b0;
    mst[idx] = 2;
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 3) begin
      @(negedge clk);
      if (!busy) q++; else q = 0;
    end
  endtask

  // Request a block; returns at the falling edge where grant_valid is first seen.
  task automatic do_alloc(input string req);
    int e;
    int lat;
    do @(negedge clk); while (!alloc_ready);
    alloc_valid = 1'b1;
    e = pick_free();
    grant_q.push_back(e);
    if (e >= 0) mst[e] = 1;
    @(posedge clk); #1 alloc_valid = 1'b0;
    lat = 0;
    do begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (lat == 1) chk(busy && !alloc_ready, "R11", "busy during walk", int'(busy), 1);
    end while (!grant_valid && lat < 200);
    chk(lat == NB + 1, req, "grant latency (R2)", lat, NB + 1);
  endtask

  // Take the posted swap and apply its effect to the model.
  task automatic take_swap(input int e);
    int w = 0;
    @(posedge clk); #1 swap_ready = 1'b1;
    while (swap_q.size() != 0 && w < 300) begin @(negedge clk); w++; end
    @(posedge clk); #1 swap_ready = 1'b0;
    if (e >= 0) begin
      mst[e / 256] = 0;
      mst[e % 256] = 1;
    end
  endtask

  // ---------------- main sequence ----------------
  initial begin
    int e;
    int lat;
    int hc;
    int hh;
    for (int i = 0; i < NB; i++) begin mcnt[i] = 0; mst[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(alloc_ready == 1'b1, "R1", "alloc_ready", int'(alloc_ready), 1);
    chk(grant_valid == 1'b0, "R1", "grant_valid", int'(grant_valid), 0);
    chk(swap_valid == 1'b0, "R1", "swap_valid", int'(swap_valid), 0);
    chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
    // R1: all counts zero, so block 0 wins the tie
    do_alloc("R1");
    release_blk(0);

    // R6: distinct wear pattern
    erase(0, 3); erase(1, 1); erase(2, 5); erase(3, 1);
    erase(4, 2); erase(5, 4); erase(6, 6); erase(7, 2);
    wait_quiet();
    // R2: lowest count, ties to lowest index
    do_alloc("R2");
    do_alloc("R2");
    do_alloc("R3");

    // R5: back-pressure on the grant
    @(posedge clk); #1 grant_ready = 1'b0;
    do_alloc("R5");
    hh = int'(grant_idx);
    repeat (5) begin
      @(negedge clk);
      chk(grant_valid && int'(grant_idx) == hh, "R5", "grant held", int'(grant_idx), hh);
      chk(!alloc_ready && busy, "R5", "not ready while grant pending (R11)", int'(alloc_ready), 0);
    end
    @(posedge clk); #1 grant_ready = 1'b1;
    wait_quiet();

    // R8: release returns a data block to the pool
    release_blk(3);
    wait_quiet();
    do_alloc("R8");

    // R7: retire a free block, try to release it
    retire(0);
    release_blk(0);
    wait_quiet();
    do_alloc("R7");
    do_alloc("R7");
    do_alloc("R7");
    // R4: nothing free
    do_alloc("R4");
    @(negedge clk);
    chk(grant_none == 1'b1, "R4", "grant_none", int'(grant_none), 1);
    wait_quiet();

    // R6: saturation, a wrap would make block 1 the lowest
    release_blk(1);
    release_blk(4);
    erase(1, 4096);
    wait_quiet();
    do_alloc("R6");
    do_alloc("R6");
    wait_quiet();

    // R9: gap equal to threshold does not trigger
    @(posedge clk); #1 thresh = 12'd5;
    release_blk(2);
    release_blk(6);
    wait_quiet();
    chk(swap_valid == 1'b0, "R9", "no swap at gap == thresh", int'(swap_valid), 0);

    // R9: gap above threshold, free-pool tie goes to the lowest index
    @(posedge clk); #1 thresh = 12'd4;
    wait_quiet();
    erase(2, 1);
    e = pick_swap();
    chk(e >= 0, "R9", "model expects a swap", e, 0);
    swap_q.push_back(e);
    lat = 0;
    do begin
      @(posedge clk); lat++;
      @(negedge clk);
    end while (!swap_valid && lat < 200);
    chk(lat == NB + 2, "R9", "swap latency", lat, NB + 2);
    hc = int'(swap_cold_idx);
    hh = int'(swap_hot_idx);

    // R10: hold while not taken, even when the gap grows
    erase(6, 1);
    repeat (3 * (NB + 2)) begin
      @(negedge clk);
      chk(swap_valid && int'(swap_cold_idx) == hc && int'(swap_hot_idx) == hh,
          "R10", "swap held", int'(swap_cold_idx) * 256 + int'(swap_hot_idx), hc * 256 + hh);
    end
    take_swap(e);

    // R10: after the handshake a second swap follows from the new pools
    e = pick_swap();
    chk(e >= 0, "R10", "model expects a second swap", e, 0);
    swap_q.push_back(e);
    take_swap(e);
    wait_quiet();
    chk(swap_valid == 1'b0, "R10", "no third swap", int'(swap_valid), 0);
    // R10: the former cold block is free again
    do_alloc("R10");
    wait_quiet();

    chk(grant_q.size() == 0, "R2", "grants left pending", grant_q.size(), 0);
    chk(swap_q.size() == 0, "R9", "swaps left pending", swap_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule